// File: doc/BRIEF.md
# Half-Duplex Byte SPI Master with Shared Data Register

This block is a byte-wide SPI master that a processor drives through a two-address register port. One address holds a data register that is used in both directions. The other address holds a small control register. A write to the data register sends that byte out, most significant bit first, over eight generated serial clocks. When read mode is enabled, a read of the data register returns the byte it currently holds and then starts eight serial clocks. During those clocks the input line is shifted into that same register. A byte is only ever sent or received, never both at once. A control bit can keep the serial output line from being driven.

Software polls the busy flag between accesses. A receive sequence works like this. Software sets read mode, then makes one read that returns stale data and only starts the first capture. Each further read returns the byte just captured and starts the next capture. Software clears read mode before the final read, so that the last byte is fetched without starting another transfer. The serial clock uses mode 0: it idles low, input is sampled on the rising edge, and output changes on the falling edge. Its period is a fixed parameter number of system clocks.

Top module: `spi_hdx_master`

## Requirements
- R1: After reset, the serial clock, serial output, output enable and busy flag are low, and a read of either register returns zero.
- R2: When output-disable is clear, a data write while idle loads the byte into the data register. It then sends the byte MSB first on the serial output with the output enable high. A new bit appears only when the serial clock falls, or at the start of the transfer.
- R3: The serial clock idles low. In each of the 8 bit periods it is low for SCK_DIV/2 system cycles and then high for the rest of SCK_DIV cycles, which gives exactly 8 rising edges per transfer.
- R4: When output-disable (control bit 0) is set, a data write still runs 8 clocks, but the output enable stays low and the serial output stays low.
- R5: With read-enable (control bit 1) set, a data read while idle returns the held byte on the read port in the next cycle and starts an 8-clock receive. The input line is sampled at each rising serial clock edge, MSB first, into the data register.
- R6: The first data read after read mode is enabled returns the byte held before the receive, not received data.
- R7: A data read with read-enable clear returns the held byte and starts no transfer: busy stays low.
- R8: No byte is sent during a receive: the output enable and serial output stay low throughout.
- R9: Busy rises in the cycle after the triggering access and stays high for exactly 8*SCK_DIV cycles.
- R10: While busy, data writes, control writes and data reads start no transfer and leave both registers unchanged.
- R11: Register address 0 is data and address 1 is control. A control read returns output-disable in bit 0, read-enable in bit 1 and busy in bit 2, with zeros above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 1 | 0 = data register, 1 = control register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after a read access |
| spi_miso | input | 1 | Serial input line |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial output line |
| spi_mosi_oe | output | 1 | Drive enable for the serial output line |
| spi_busy | output | 1 | Transfer in progress |

## Verification
The assertions check these rules on every cycle:
- the serial clock stays low when idle;
- the serial output stays quiet whenever it is not enabled;
- the serial output changes only when the clock falls;
- every transfer has exactly 8*SCK_DIV busy cycles and eight rising edges;
- control writes made while busy change nothing.

Only the bench scenarios can show the rest: that the right byte leaves MSB first, that captured bytes land in the register in order, that the first read after enabling read mode returns stale data, and that reads made with read mode off or while busy start nothing. The bench does this through a reference model that tracks the elapsed cycle count of each transfer.

// File: rtl/spi_hdx_pkg.sv
package spi_hdx_pkg;
  localparam logic ADDR_DATA = 1'b0;
  localparam logic ADDR_CTRL = 1'b1;

  localparam int CTRL_DIS_BIT  = 0;
  localparam int CTRL_RDEN_BIT = 1;
  localparam int CTRL_BUSY_BIT = 2;

  typedef enum logic {
    DIR_TX = 1'b0,
    DIR_RX = 1'b1
  } xfer_dir_t;
endpackage

// File: rtl/spi_hdx_clkgen.sv
module spi_hdx_clkgen #(
  parameter int SCK_DIV = 4,
  parameter int NBITS   = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic sck,
  output logic rise_now,
  output logic fall_now,
  output logic last_now
);
  localparam int HALF = SCK_DIV / 2;
  localparam int CW   = $clog2(SCK_DIV);
  localparam int BW   = $clog2(NBITS);
  localparam logic [CW-1:0] PH_RISE  = CW'(HALF - 1);
  localparam logic [CW-1:0] PH_LAST  = CW'(SCK_DIV - 1);
  localparam logic [BW-1:0] BIT_LAST = BW'(NBITS - 1);

  logic [CW-1:0] ph_q;
  logic [BW-1:0] bit_q;

  // strobes mark the edge at which the serial clock will change
  assign rise_now = busy && (ph_q == PH_RISE);
  assign fall_now = busy && (ph_q == PH_LAST);
  assign last_now = fall_now && (bit_q == BIT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      sck   <= 1'b0;
      ph_q  <= '0;
      bit_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      sck   <= 1'b0;
      ph_q  <= '0;
      bit_q <= '0;
    end else if (busy) begin
      ph_q <= fall_now ? '0 : ph_q + 1'b1;
      if (rise_now) sck <= 1'b1;
      if (fall_now) begin
        sck   <= 1'b0;
        bit_q <= bit_q + 1'b1;
        if (last_now) busy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_hdx_shifter.sv
module spi_hdx_shifter
  import spi_hdx_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_tx,
  input  logic             start_rx,
  input  logic             out_dis,
  input  logic [NBITS-1:0] wdata,
  input  logic             rise_now,
  input  logic             fall_now,
  input  logic             last_now,
  input  logic             miso,
  output logic [NBITS-1:0] data_q,
  output logic             mosi,
  output logic             mosi_oe
);
  logic [NBITS-1:0] sh_q;
  xfer_dir_t        dir_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q  <= '0;
      sh_q    <= '0;
      dir_q   <= DIR_TX;
      mosi    <= 1'b0;
      mosi_oe <= 1'b0;
    end else if (start_tx) begin
      data_q  <= wdata;
      sh_q    <= wdata;
      dir_q   <= DIR_TX;
      mosi_oe <= !out_dis;
      mosi    <= !out_dis && wdata[NBITS-1];
    end else if (start_rx) begin
      dir_q   <= DIR_RX;
      mosi_oe <= 1'b0;
      mosi    <= 1'b0;
    end else begin
      if (dir_q == DIR_RX && rise_now)
        data_q <= {data_q[NBITS-2:0], miso};
      if (last_now) begin
        mosi    <= 1'b0;
        mosi_oe <= 1'b0;
      end else if (fall_now && dir_q == DIR_TX) begin
        sh_q <= sh_q << 1;
        mosi <= mosi_oe && sh_q[NBITS-2];
      end
    end
  end
endmodule

// File: rtl/spi_hdx_regs.sv
module spi_hdx_regs
  import spi_hdx_pkg::*;
#(
  parameter int NBITS = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel,
  input  logic             we,
  input  logic             addr,
  input  logic [NBITS-1:0] wdata,
  input  logic             busy,
  input  logic [NBITS-1:0] data_q,
  output logic             start_tx,
  output logic             start_rx,
  output logic             out_dis,
  output logic             rd_en,
  output logic [NBITS-1:0] rdata
);
  logic             ctrl_wr;
  logic [NBITS-1:0] ctrl_view;

  assign start_tx = sel && we && (addr == ADDR_DATA) && !busy;
  assign start_rx = sel && !we && (addr == ADDR_DATA) && !busy && rd_en;
  assign ctrl_wr  = sel && we && (addr == ADDR_CTRL) && !busy;

  always_comb begin
    ctrl_view                = '0;
    ctrl_view[CTRL_DIS_BIT]  = out_dis;
    ctrl_view[CTRL_RDEN_BIT] = rd_en;
    ctrl_view[CTRL_BUSY_BIT] = busy;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_dis <= 1'b0;
      rd_en   <= 1'b0;
      rdata   <= '0;
    end else begin
      if (ctrl_wr) begin
        out_dis <= wdata[CTRL_DIS_BIT];
        rd_en   <= wdata[CTRL_RDEN_BIT];
      end
      if (sel && !we)
        rdata <= (addr == ADDR_CTRL) ? ctrl_view : data_q;
    end
  end
endmodule

// File: rtl/spi_hdx_master.sv
module spi_hdx_master #(
  parameter int SCK_DIV = 4,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic              bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              spi_miso,
  output logic              spi_sck,
  output logic              spi_mosi,
  output logic              spi_mosi_oe,
  output logic              spi_busy
);
  logic              start_tx, start_rx;
  logic              out_dis, rd_en;
  logic              rise_now, fall_now, last_now;
  logic [DATA_W-1:0] data_q;

  spi_hdx_regs #(.NBITS(DATA_W)) u_regs (
    .clk(clk), .rst(rst), .sel(bus_sel), .we(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .busy(spi_busy), .data_q(data_q),
    .start_tx(start_tx), .start_rx(start_rx), .out_dis(out_dis),
    .rd_en(rd_en), .rdata(bus_rdata)
  );

  spi_hdx_clkgen #(.SCK_DIV(SCK_DIV), .NBITS(DATA_W)) u_clkgen (
    .clk(clk), .rst(rst), .start(start_tx || start_rx), .busy(spi_busy),
    .sck(spi_sck), .rise_now(rise_now), .fall_now(fall_now),
    .last_now(last_now)
  );

  spi_hdx_shifter #(.NBITS(DATA_W)) u_shifter (
    .clk(clk), .rst(rst), .start_tx(start_tx), .start_rx(start_rx),
    .out_dis(out_dis), .wdata(bus_wdata), .rise_now(rise_now),
    .fall_now(fall_now), .last_now(last_now), .miso(spi_miso),
    .data_q(data_q), .mosi(spi_mosi), .mosi_oe(spi_mosi_oe)
  );
endmodule

// File: rtl/spi_hdx_checker.sv
module spi_hdx_checker #(
  parameter int SCK_DIV = 4,
  parameter int NBITS   = 8
) (
  input logic clk,
  input logic rst,
  input logic busy,
  input logic sck,
  input logic mosi,
  input logic mosi_oe,
  input logic bus_sel,
  input logic bus_we,
  input logic out_dis,
  input logic rd_en
);
  localparam logic [15:0] TOTAL = 16'(SCK_DIV * NBITS);
  localparam logic [15:0] EDGES = 16'(NBITS);

  logic [15:0] busy_cnt;
  logic [15:0] rise_cnt;
  logic        sck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_cnt <= '0;
      rise_cnt <= '0;
      sck_prev <= 1'b0;
    end else begin
      sck_prev <= sck;
      busy_cnt <= busy ? busy_cnt + 1'b1 : '0;
      if (!busy)              rise_cnt <= '0;
      else if (sck && !sck_prev) rise_cnt <= rise_cnt + 1'b1;
    end
  end

  a_r3_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sck);

  a_r4_mosi_quiet_undriven: assert property (@(posedge clk) disable iff (rst)
    !mosi_oe |-> !mosi);

  a_r8_no_drive_idle: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mosi_oe);

  a_r2_mosi_moves_on_fall: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$fell(sck)) |-> $stable(mosi));

  a_r9_busy_length: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (busy_cnt == TOTAL));

  a_r3_eight_rises: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (rise_cnt == EDGES));

  a_r10_ctrl_held_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && bus_sel && bus_we) |=> ($stable(out_dis) && $stable(rd_en)));
endmodule

bind spi_hdx_master spi_hdx_checker #(.SCK_DIV(SCK_DIV), .NBITS(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .busy(spi_busy), .sck(spi_sck), .mosi(spi_mosi),
  .mosi_oe(spi_mosi_oe), .bus_sel(bus_sel), .bus_we(bus_we),
  .out_dis(out_dis), .rd_en(rd_en)
);

// File: tb/spi_hdx_master_test.sv
`timescale 1ns/1ps
module spi_hdx_master_test;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 1'b0, bus_we = 1'b0, bus_addr = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic       spi_miso = 1'b0;
  logic       spi_sck, spi_mosi, spi_mosi_oe, spi_busy;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  always #5 clk = ~clk;

  spi_hdx_master #(.SCK_DIV(DIV), .DATA_W(8)) uut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .spi_miso(spi_miso), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_mosi_oe(spi_mosi_oe), .spi_busy(spi_busy)
  );

  // reference model state
  bit         m_active, m_rx, m_drv, m_dis, m_rden, was;
  int         m_e;
  logic [7:0] m_byte, m_data, m_rdata;
  logic [7:0] slave_byte = 8'h00;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_active = 0; m_rx = 0; m_drv = 0; m_dis = 0; m_rden = 0;
      m_e = 0; m_byte = 8'h00; m_data = 8'h00; m_rdata = 8'h00;
    end else begin
      was = m_active;
      if (bus_sel && !bus_we)
        m_rdata = bus_addr ? {5'b0, was, m_rden, m_dis} : m_data;
      if (was) begin
        m_e++;
        if (m_rx && (m_e % DIV) == HALF) m_data = {m_data[6:0], spi_miso};
        if (m_e == 8 * DIV) m_active = 0;
      end else if (bus_sel) begin
        if (bus_we && !bus_addr) begin
          m_active = 1; m_e = 0; m_rx = 0; m_byte = bus_wdata;
          m_data = bus_wdata; m_drv = !m_dis;
        end else if (bus_we && bus_addr) begin
          m_dis = bus_wdata[0]; m_rden = bus_wdata[1];
        end else if (!bus_addr && m_rden) begin
          m_active = 1; m_e = 0; m_rx = 1; m_drv = 0;
        end
      end
    end
  end

  // per-cycle comparison and slave drive
  always @(negedge clk) begin
    if (!rst) begin
      int k;
      logic e_sck, e_oe, e_mosi;
      k      = m_e / DIV;
      e_sck  = m_active && ((m_e % DIV) >= HALF);
      e_oe   = m_active && !m_rx && m_drv;
      e_mosi = e_oe && m_byte[7 - k];
      chk("R9 busy", {7'b0, spi_busy}, {7'b0, m_active});
      chk("R3 sck", {7'b0, spi_sck}, {7'b0, e_sck});
      chk("R8 oe", {7'b0, spi_mosi_oe}, {7'b0, e_oe});
      chk("R2 mosi", {7'b0, spi_mosi}, {7'b0, e_mosi});
      chk("R11 rdata", bus_rdata, m_rdata);
      spi_miso = (m_active && m_rx) ? slave_byte[7 - k] : 1'b0;
    end
  end

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    v = bus_rdata;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!spi_busy) break;
    end
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 sck", {7'b0, spi_sck}, 8'h00);
    chk("R1 busy", {7'b0, spi_busy}, 8'h00);
    chk("R1 oe", {7'b0, spi_mosi_oe}, 8'h00);
    rd(1'b1, v); chk("R11 ctrl reset", v, 8'h00);
    rd(1'b0, v); chk("R1 data reset", v, 8'h00);
    chk("R7 no transfer when read disabled", {7'b0, spi_busy}, 8'h00);

    wr(1'b0, 8'hA5);
    chk("R9 busy after write", {7'b0, spi_busy}, 8'h01);
    chk("R2 first bit", {7'b0, spi_mosi}, 8'h01);
    wait_idle();
    rd(1'b0, v); chk("R2 data holds written byte", v, 8'hA5);

    wr(1'b0, 8'h3C);
    wr(1'b0, 8'hFF);
    wr(1'b1, 8'h03);
    wait_idle();
    rd(1'b1, v); chk("R10 ctrl unchanged", v, 8'h00);
    rd(1'b0, v); chk("R10 data unchanged", v, 8'h3C);

    wr(1'b1, 8'h01);
    wr(1'b0, 8'h81);
    @(negedge clk);
    chk("R4 oe low when disabled", {7'b0, spi_mosi_oe}, 8'h00);
    chk("R4 busy still runs", {7'b0, spi_busy}, 8'h01);
    wait_idle();
    rd(1'b1, v); chk("R11 ctrl dis", v, 8'h01);

    wr(1'b1, 8'h02);
    slave_byte = 8'h5A;
    rd(1'b0, v); chk("R6 first read stale", v, 8'h81);
    chk("R5 receive started", {7'b0, spi_busy}, 8'h01);
    wait_idle();
    slave_byte = 8'hC3;
    rd(1'b0, v); chk("R5 received byte", v, 8'h5A);
    rd(1'b1, v); chk("R11 ctrl busy view", v, 8'h06);
    rd(1'b0, v);
    wait_idle();
    @(negedge clk);
    chk("R10 read while busy started nothing", {7'b0, spi_busy}, 8'h00);
    wr(1'b1, 8'h00);
    rd(1'b0, v); chk("R5 second received byte", v, 8'hC3);
    chk("R7 final read starts nothing", {7'b0, spi_busy}, 8'h00);

    repeat (4) @(negedge clk);
    summary();
    $finish;
  end
endmodule